// File: doc/BRIEF.md
# AAL1 Sequence Number Checker

This block screens the one-byte AAL1 header that accompanies each cell-arrival pulse for a single virtual circuit. The 3-bit CRC field and the even parity bit are verified first. A cell that fails either check is dropped, and a sticky flag is raised for that kind of error. A cell that passes has its 3-bit count compared with the count of the last accepted cell. The checker then classifies the arrival as in sequence, one cell lost, several cells lost or misinserted.

The outputs feed a downstream cell counter. An accepted cell produces a one-cycle valid pulse. When exactly one cell went missing, a one-cycle lost pulse fires in the same cycle, so the counter can make up for the gap. Larger gaps and out-of-order arrivals are only flagged. Five sticky status bits can be read at any time and are cleared together by a strobe.

Top module: `aal1_seq_check`

## Requirements
- R1: Header bits 3:1 must equal the CRC-3 (generator x^3+x+1, remainder of bits 7:4 shifted left by three) of header bits 7:4. On a mismatch, status bit 0 is set, no pulse is produced and the reference count is left unchanged.
- R2: The XOR of all eight header bits must be 0 (even parity, bit 0 being the parity bit). Otherwise status bit 1 is set, no pulse is produced and the reference count is left unchanged.
- R3: After reset, the first cell that passes both checks produces a valid pulse with no lost pulse and no status bit, and its count (bits 6:4) becomes the reference.
- R4: Pulses are registered. valid_pulse and lost_pulse are high for exactly the one cycle after the clock edge that samples arrive. An accepted cell whose count is the reference plus 1 (mod 8) gives a valid pulse only.
- R5: A count that is the reference plus 2 (mod 8) gives a valid pulse and a lost pulse in the same cycle, and sets status bit 2.
- R6: A count that is the reference plus 3 to 6 (mod 8) gives a valid pulse without a lost pulse, sets status bit 3, and makes the received count the new reference.
- R7: A count equal to the reference, or the reference minus 1 (mod 8), sets status bit 4. The cell is dropped with no pulse, and the reference is left unchanged.
- R8: Status bits stay set until clr is sampled high, which clears all five. A flag raised in the same cycle as clr is kept.
- R9: During and right after reset, both pulses and all status bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arrive | input | 1 | One-cycle cell-arrival strobe |
| hdr | input | 8 | AAL1 header byte valid with arrive |
| clr | input | 1 | Clears all sticky status bits |
| valid_pulse | output | 1 | Accepted cell, one cycle |
| lost_pulse | output | 1 | Compensation for one lost cell, one cycle |
| status | output | 5 | Sticky flags: 0 CRC, 1 parity, 2 single loss, 3 multi loss, 4 misinserted |

## Verification
Every pair of reference count and next count (64 pairs, each starting from reset) is sent with correct headers. This separates the in-sequence, single-loss, multi-loss and misinsertion classes by their pulses and flags. A follow-up cell after each misinsertion or multi-loss shows whether the reference was kept or moved. All 256 header bytes are then tried against a known reference. This separates CRC failures from parity failures and confirms that a rejected byte leaves the sequence state alone. Separate sequences cover pulse width and clear-strobe priority.

// File: rtl/aal1_seq_check.sv
module aal1_seq_check (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arrive,
  input  logic [7:0] hdr,
  input  logic       clr,
  output logic       valid_pulse,
  output logic       lost_pulse,
  output logic [4:0] status
);

  function automatic logic [2:0] crc3(input logic [3:0] d);
    logic [6:0] r;
    r = {d, 3'b000};
    for (int i = 6; i >= 3; i--)
      if (r[i]) r = r ^ (7'b0001011 << (i - 3));
    return r[2:0];
  endfunction

  logic [2:0] last;
  logic       synced;

  wire        crc_bad = crc3(hdr[7:4]) != hdr[3:1];
  wire        par_bad = ^hdr;
  wire  [2:0] seq     = hdr[6:4];
  wire  [2:0] diff    = seq - last;
  wire        good    = arrive && !crc_bad && !par_bad;
  wire        mis     = good && synced && (diff == 3'd0 || diff == 3'd7);
  wire        single  = good && synced && diff == 3'd2;
  wire        multi   = good && synced && diff >= 3'd3 && diff <= 3'd6;
  wire        accept  = good && !mis;
  wire  [4:0] raised  = {mis, multi, single, arrive && par_bad, arrive && crc_bad};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_pulse <= 1'b0;
      lost_pulse  <= 1'b0;
      status      <= '0;
      last        <= '0;
      synced      <= 1'b0;
    end else begin
      valid_pulse <= accept;
      lost_pulse  <= single;
      status      <= (clr ? 5'd0 : status) | raised;
      if (accept) begin
        last   <= seq;
        synced <= 1'b1;
      end
    end
  end

  AST_LOST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    lost_pulse |-> valid_pulse); // R5
  AST_PULSE_NEEDS_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
    valid_pulse |-> $past(arrive)); // R4
  AST_BAD_PARITY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (arrive && ^hdr) |=> !valid_pulse); // R2
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr) |-> ((status & $past(status)) == $past(status))); // R8
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr) && !$past(arrive)) |-> status == 5'd0); // R8

endmodule

// File: tb/sim_aal1_seq_check.sv
module sim_aal1_seq_check;
  logic clk = 1'b0, rst_n = 1'b0, arrive = 1'b0, clr = 1'b0;
  logic [7:0] hdr = '0;
  logic valid_pulse, lost_pulse;
  logic [4:0] status;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  aal1_seq_check u0 (.clk(clk), .rst_n(rst_n), .arrive(arrive), .hdr(hdr), .clr(clr),
                     .valid_pulse(valid_pulse), .lost_pulse(lost_pulse), .status(status));

  function automatic logic [2:0] ref_crc(input logic [3:0] d);
    logic [2:0] c = 3'b000;
    for (int i = 3; i >= 0; i--) begin
      logic fb = d[i] ^ c[2];
      c = {c[1:0], 1'b0} ^ (fb ? 3'b011 : 3'b000);
    end
    return c;
  endfunction

  function automatic logic [7:0] mk(input logic ci, input logic [2:0] cnt);
    logic [7:0] b = {ci, cnt, ref_crc({ci, cnt}), 1'b0};
    b[0] = ^b[7:1];
    return b;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic send(input logic [7:0] h);
    @(negedge clk) begin arrive = 1'b1; hdr = h; end
    @(negedge clk) arrive = 1'b0;
  endtask

  task automatic expect_out(input string req, input logic v, input logic l, input logic [4:0] s);
    check(req, {6'd0, valid_pulse, lost_pulse}, {6'd0, v, l});
    check(req, {3'd0, status}, {3'd0, s});
  endtask

  initial begin
    #1500000;
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    expect_out("R9 in reset", 1'b0, 1'b0, 5'd0);
    @(negedge clk) rst_n = 1'b1;
    expect_out("R9 after reset", 1'b0, 1'b0, 5'd0);

    // R3..R7: every reference/next count pair
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        int d;
        logic [4:0] s;
        d = (b - a) & 7;
        do_reset();
        send(mk(a[0], a[2:0]));
        expect_out("R3 first cell", 1'b1, 1'b0, 5'd0);
        send(mk(b[1], b[2:0]));
        if (d == 1) begin
          expect_out("R4 in sequence", 1'b1, 1'b0, 5'd0);
          @(negedge clk);
          expect_out("R4 one-cycle pulse", 1'b0, 1'b0, 5'd0);
        end else if (d == 2) begin
          expect_out("R5 single loss", 1'b1, 1'b1, 5'b00100);
        end else if (d == 0 || d == 7) begin
          s = 5'b10000;
          expect_out("R7 misinserted", 1'b0, 1'b0, s);
          send(mk(1'b0, 3'((a + 1) & 7)));
          expect_out("R7 reference kept", 1'b1, 1'b0, s);
        end else begin
          s = 5'b01000;
          expect_out("R6 multi loss", 1'b1, 1'b0, s);
          send(mk(1'b1, 3'((b + 1) & 7)));
          expect_out("R6 resync", 1'b1, 1'b0, s);
        end
      end
    end

    // R1/R2: every header byte against reference count (cnt-1)
    for (int h = 0; h < 256; h++) begin
      logic [7:0] hb;
      logic cb, pb;
      logic [2:0] rc;
      hb = h[7:0];
      cb = ref_crc(hb[7:4]) != hb[3:1];
      pb = ^hb;
      rc = hb[6:4] - 3'd1;
      do_reset();
      send(mk(1'b0, rc));
      send(hb);
      if (cb || pb) begin
        expect_out(cb ? "R1 crc reject" : "R2 parity reject", 1'b0, 1'b0, {3'b000, pb, cb});
        send(mk(1'b0, rc + 3'd1));
        expect_out("R1 R2 reference unchanged", 1'b1, 1'b0, {3'b000, pb, cb});
      end else begin
        expect_out("R1 R2 good header", 1'b1, 1'b0, 5'd0);
      end
    end

    // R8: sticky and clear
    do_reset();
    send(mk(1'b0, 3'd0));
    send(mk(1'b0, 3'd0));
    send(8'h01);
    @(negedge clk);
    expect_out("R8 sticky", 1'b0, 1'b0, 5'b10010);
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    expect_out("R8 clear", 1'b0, 1'b0, 5'd0);
    @(negedge clk) begin clr = 1'b1; arrive = 1'b1; hdr = 8'h01; end
    @(negedge clk) begin clr = 1'b0; arrive = 1'b0; end
    expect_out("R8 set beats clear", 1'b0, 1'b0, 5'b00010);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule